// File: doc/BRIEF.md
# Codec Command and Response Rings

This block moves control traffic between a host and a set of attached codecs through two rings kept in shared memory. The host places 32-bit verbs in the command ring and advances the command write pointer. The block then walks the ring: it steps its read pointer first, fetches the verb at the new index, and hands it to the codec side on a valid/ready output tagged with the codec address from the top nibble of the verb. Verbs aimed at a codec that is not attached are discarded without being presented.

Replies from the codecs arrive on a response input carrying a data word, the codec address and an unsolicited marker. Each reply is stored as a two-word entry in the response ring at the next write index. A reply counter compared with a host-set threshold raises a sticky interrupt flag that the host clears by writing a one to it. Both rings share one word-addressed memory port with a fixed one-cycle read latency; response writes take the port ahead of command fetches.

Host registers (4-bit address, 8-bit data, write-only; state is observed on dedicated outputs): 0 command write pointer, 1 command read pointer, 2 command control (bit 0 run), 3 command size select, 4 response write pointer, 5 response control (bit 0 ring enable, bit 1 interrupt enable), 6 response size select, 7 interrupt threshold, 8 status (bit 0 interrupt flag, write one to clear).

Top module: `codec_ring_ctrl`

## Requirements
- R1: After reset the command read pointer, response write pointer and interrupt flag read 0, no verb is offered, the response input is not ready, and both size selects hold code 2 (256 entries).
- R2: A size select of 0, 1 or 2 gives a ring of 2, 16 or 256 entries; code 3 is invalid: the command engine does not start on a run edge with it and the response input stays not ready.
- R3: The command engine starts on a 0-to-1 change of the run bit; while started and the read pointer differs from the write pointer, it sets the read pointer to (pointer + 1) modulo the ring size, publishes it on cmd_rp_o and reads word CMD_BASE + pointer.
- R4: Bits 31:28 of a fetched verb give the codec address; a verb whose address is at or above NUM_CODECS is dropped, any other is offered on verb_o with verb_cad_o and held stable until verb_ready_i.
- R5: Clearing the run bit withdraws any offered verb and stops fetches on the next cycle; the read pointer register accepts host writes only while the run bit is clear.
- R6: While the response ring is enabled with a valid size, each accepted reply advances the write pointer modulo the size before storing; word RSP_BASE + 2*pointer receives the data and the following word receives the codec address in bits 3:0 with the unsolicited marker in bit 4.
- R7: Each stored reply increments a counter; when the incremented count equals the threshold and the interrupt enable is set, the flag rises and the counter returns to 0; with the enable clear the flag does not rise; writing 1 to status bit 0 clears the flag.
- R8: Clearing the response enable makes the input not ready, zeroes the reply counter, and allows host writes to the response write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| cmd_rp_o | output | 8 | Published command read pointer |
| rsp_wp_o | output | 8 | Response write pointer |
| rsp_irq_o | output | 1 | Sticky response interrupt flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, one cycle after a read request |
| verb_valid_o | output | 1 | Verb offered to codecs |
| verb_ready_i | input | 1 | Codec side accepts verb |
| verb_o | output | DW | Verb word |
| verb_cad_o | output | 4 | Codec address of the verb |
| rsp_valid_i | input | 1 | Reply available |
| rsp_ready_o | output | 1 | Reply accepted this cycle when valid |
| rsp_data_i | input | DW | Reply data word |
| rsp_unsol_i | input | 1 | Reply is unsolicited |
| rsp_cad_i | input | 4 | Codec address of the reply |

## Verification
The bench builds the block with NUM_CODECS of 3, a 10-bit word address, command ring at word 0 and response ring at word 512, backed by a 1024-word memory model. Three attached codecs make the drop of an address-3 verb directly observable next to accepted addresses 0 to 2, and the separate ring bases let every stored response word be checked by location. The small word address keeps the full 256-entry default ring reachable, so the default size is told apart from the 16-entry one by the fetched index, and the 2-entry select exercises wrap on both rings within a few cycles.

// File: rtl/codec_ring_pkg.sv
package codec_ring_pkg;

  localparam int PTR_W = 8;

  // ring size codes
  localparam logic [1:0] SZ_2   = 2'd0;
  localparam logic [1:0] SZ_16  = 2'd1;
  localparam logic [1:0] SZ_256 = 2'd2;

  // register addresses
  localparam logic [3:0] RA_CMD_WP  = 4'h0;
  localparam logic [3:0] RA_CMD_RP  = 4'h1;
  localparam logic [3:0] RA_CMD_CTL = 4'h2;
  localparam logic [3:0] RA_CMD_SZ  = 4'h3;
  localparam logic [3:0] RA_RSP_WP  = 4'h4;
  localparam logic [3:0] RA_RSP_CTL = 4'h5;
  localparam logic [3:0] RA_RSP_SZ  = 4'h6;
  localparam logic [3:0] RA_RSP_TH  = 4'h7;
  localparam logic [3:0] RA_STAT    = 4'h8;

  typedef enum logic [1:0] {C_IDLE, C_REQ, C_WAIT, C_SEND} cmd_st_e;
  typedef enum logic [1:0] {R_IDLE, R_W0, R_W1} rsp_st_e;

  function automatic logic [PTR_W-1:0] ring_mask(input logic [1:0] sel);
    case (sel)
      SZ_2:    ring_mask = 8'h01;
      SZ_16:   ring_mask = 8'h0F;
      SZ_256:  ring_mask = 8'hFF;
      default: ring_mask = 8'h00;
    endcase
  endfunction

  function automatic logic size_ok(input logic [1:0] sel);
    size_ok = (sel != 2'd3);
  endfunction

endpackage

// File: rtl/codec_cmd_fetch.sv
module codec_cmd_fetch
  import codec_ring_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int CMD_BASE   = 0,
  parameter int NUM_CODECS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       size_sel_i,
  input  logic [PTR_W-1:0] wp_i,
  input  logic             rp_wr_i,
  input  logic [PTR_W-1:0] rp_wdata_i,
  input  logic             gnt_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic [PTR_W-1:0] rp_o,
  output logic             verb_valid_o,
  output logic [DW-1:0]    verb_o,
  output logic [3:0]       verb_cad_o,
  input  logic             verb_ready_i
);

  localparam logic [AW-1:0] BASE_A = AW'(CMD_BASE);
  localparam logic [4:0]    NCOD   = 5'(NUM_CODECS);

  cmd_st_e          st_q;
  logic             run_q, active_q;
  logic [PTR_W-1:0] rp_q, nxt_idx;
  logic [DW-1:0]    verb_q;
  logic [3:0]       rd_cad;

  assign nxt_idx = (rp_q + 8'd1) & ring_mask(size_sel_i);
  assign rd_cad  = rdata_i[DW-1 -: 4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= C_IDLE;
      run_q    <= 1'b0;
      active_q <= 1'b0;
      rp_q     <= '0;
      verb_q   <= '0;
    end else begin
      run_q <= run_i;
      if (!run_i) begin
        active_q <= 1'b0;
        st_q     <= C_IDLE;
        if (rp_wr_i) rp_q <= rp_wdata_i;
      end else begin
        if (!run_q && size_ok(size_sel_i)) active_q <= 1'b1;
        case (st_q)
          C_IDLE: if (active_q && rp_q != wp_i) st_q <= C_REQ;
          C_REQ:  if (gnt_i) begin
                    rp_q <= nxt_idx;   // pre-increment, published at fetch
                    st_q <= C_WAIT;
                  end
          C_WAIT: begin
                    verb_q <= rdata_i;
                    st_q   <= ({1'b0, rd_cad} < NCOD) ? C_SEND : C_IDLE;
                  end
          C_SEND: if (verb_ready_i) st_q <= C_IDLE;
          default: st_q <= C_IDLE;
        endcase
      end
    end
  end

  assign rd_req_o     = (st_q == C_REQ);
  assign rd_addr_o    = BASE_A + AW'(nxt_idx);
  assign rp_o         = rp_q;
  assign verb_valid_o = (st_q == C_SEND);
  assign verb_o       = verb_q;
  assign verb_cad_o   = verb_q[DW-1 -: 4];

  // R4
  verb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verb_valid_o && !verb_ready_i && run_i) |=> (verb_valid_o && $stable(verb_o)));
  // R4
  cad_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verb_valid_o |-> ({1'b0, verb_cad_o} < NCOD));
  // R5
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!verb_valid_o && !rd_req_o));
  // R3
  rp_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(rd_req_o && gnt_i)) |=> $stable(rp_o));

endmodule

// File: rtl/codec_rsp_writer.sv
module codec_rsp_writer
  import codec_ring_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int RSP_BASE = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_en_i,
  input  logic             irq_en_i,
  input  logic [1:0]       size_sel_i,
  input  logic [7:0]       thresh_i,
  input  logic             wp_wr_i,
  input  logic [PTR_W-1:0] wp_wdata_i,
  input  logic             rsp_valid_i,
  input  logic [DW-1:0]    rsp_data_i,
  input  logic             rsp_unsol_i,
  input  logic [3:0]       rsp_cad_i,
  output logic             rsp_ready_o,
  output logic             wr_req_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [PTR_W-1:0] wp_o,
  output logic             irq_set_o
);

  localparam logic [AW-1:0] BASE_A = AW'(RSP_BASE);

  rsp_st_e          st_q;
  logic [PTR_W-1:0] wp_q;
  logic [DW-1:0]    data_q;
  logic [4:0]       ext_q;
  logic [7:0]       cnt_q, cnt_nxt;

  assign cnt_nxt     = cnt_q + 8'd1;
  assign rsp_ready_o = dma_en_i && size_ok(size_sel_i) && (st_q == R_IDLE);
  assign irq_set_o   = (st_q == R_W1) && irq_en_i && (cnt_nxt == thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_IDLE;
      wp_q   <= '0;
      data_q <= '0;
      ext_q  <= '0;
      cnt_q  <= '0;
    end else if (!dma_en_i) begin
      st_q  <= R_IDLE;
      cnt_q <= '0;
      if (wp_wr_i) wp_q <= wp_wdata_i;
    end else begin
      case (st_q)
        R_IDLE: if (rsp_valid_i && rsp_ready_o) begin
                  wp_q   <= (wp_q + 8'd1) & ring_mask(size_sel_i);
                  data_q <= rsp_data_i;
                  ext_q  <= {rsp_unsol_i, rsp_cad_i};
                  st_q   <= R_W0;
                end
        R_W0:   st_q <= R_W1;
        R_W1:   begin
                  st_q  <= R_IDLE;
                  cnt_q <= irq_set_o ? 8'd0 : cnt_nxt;
                end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  assign wr_req_o  = (st_q != R_IDLE);
  assign wr_addr_o = BASE_A + AW'({wp_q, st_q == R_W1});
  assign wr_data_o = (st_q == R_W1) ? DW'(ext_q) : data_q;
  assign wp_o      = wp_q;

  // R6
  pair_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_addr_o[0] && dma_en_i) |=> (wr_req_o && wr_addr_o[0]));
  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_o |=> (cnt_q == 8'd0));
  // R8
  dma_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> (!wr_req_o && cnt_q == 8'd0));

endmodule

// File: rtl/codec_ring_ctrl.sv
module codec_ring_ctrl
  import codec_ring_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int CMD_BASE   = 0,
  parameter int RSP_BASE   = 512,
  parameter int NUM_CODECS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    cmd_rp_o,
  output logic [7:0]    rsp_wp_o,
  output logic          rsp_irq_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          verb_valid_o,
  input  logic          verb_ready_i,
  output logic [DW-1:0] verb_o,
  output logic [3:0]    verb_cad_o,
  input  logic          rsp_valid_i,
  output logic          rsp_ready_o,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_unsol_i,
  input  logic [3:0]    rsp_cad_i
);

  logic [7:0]    cmd_wp_q, thresh_q;
  logic [1:0]    cmd_sz_q, rsp_sz_q;
  logic          run_q, dma_q, ien_q, irq_q;
  logic          rp_wr, wp_wr, irq_set;
  logic          rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  assign rp_wr = reg_we_i && (reg_addr_i == RA_CMD_RP);
  assign wp_wr = reg_we_i && (reg_addr_i == RA_RSP_WP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_wp_q <= '0;
      thresh_q <= '0;
      cmd_sz_q <= SZ_256;
      rsp_sz_q <= SZ_256;
      run_q    <= 1'b0;
      dma_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CMD_WP:  cmd_wp_q <= reg_wdata_i;
        RA_CMD_CTL: run_q    <= reg_wdata_i[0];
        RA_CMD_SZ:  cmd_sz_q <= reg_wdata_i[1:0];
        RA_RSP_CTL: {ien_q, dma_q} <= reg_wdata_i[1:0];
        RA_RSP_SZ:  rsp_sz_q <= reg_wdata_i[1:0];
        RA_RSP_TH:  thresh_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  // sticky flag, set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (reg_we_i && reg_addr_i == RA_STAT && reg_wdata_i[0]) irq_q <= 1'b0;
  end
  assign rsp_irq_o = irq_q;

  codec_cmd_fetch #(.AW(AW), .DW(DW), .CMD_BASE(CMD_BASE), .NUM_CODECS(NUM_CODECS)) u_cmd (
    .clk_i, .rst_ni,
    .run_i(run_q), .size_sel_i(cmd_sz_q), .wp_i(cmd_wp_q),
    .rp_wr_i(rp_wr), .rp_wdata_i(reg_wdata_i),
    .gnt_i(!wr_req), .rdata_i(mem_rdata_i),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rp_o(cmd_rp_o),
    .verb_valid_o, .verb_o, .verb_cad_o, .verb_ready_i
  );

  codec_rsp_writer #(.AW(AW), .DW(DW), .RSP_BASE(RSP_BASE)) u_rsp (
    .clk_i, .rst_ni,
    .dma_en_i(dma_q), .irq_en_i(ien_q), .size_sel_i(rsp_sz_q), .thresh_i(thresh_q),
    .wp_wr_i(wp_wr), .wp_wdata_i(reg_wdata_i),
    .rsp_valid_i, .rsp_data_i, .rsp_unsol_i, .rsp_cad_i, .rsp_ready_o,
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wp_o(rsp_wp_o), .irq_set_o(irq_set)
  );

  // response writes own the port ahead of fetches
  assign mem_req_o   = wr_req || rd_req;
  assign mem_we_o    = wr_req;
  assign mem_addr_o  = wr_req ? wr_addr : rd_addr;
  assign mem_wdata_o = wr_data;

  // R7
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_irq_o) |-> $past(ien_q));
  // R2
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_sz_q == 2'd3) |-> !rsp_ready_o);

endmodule

// File: tb/sim_codec_ring_ctrl.sv
module sim_codec_ring_ctrl;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int RB = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] cmd_rp, rsp_wp;
  logic rsp_irq, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic verb_valid, verb_ready = 1'b1;
  logic [DW-1:0] verb;
  logic [3:0] verb_cad;
  logic rsp_valid = 1'b0, rsp_ready, rsp_unsol = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic [3:0] rsp_cad = '0;

  logic [DW-1:0] mem [0:1023];
  logic [DW-1:0] got [0:63];
  logic [3:0]    got_cad [0:63];
  int nv = 0, checks = 0, errors = 0;

  always #5 clk = ~clk;

  codec_ring_ctrl #(.AW(AW), .DW(DW), .CMD_BASE(0), .RSP_BASE(RB), .NUM_CODECS(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .cmd_rp_o(cmd_rp), .rsp_wp_o(rsp_wp), .rsp_irq_o(rsp_irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .verb_valid_o(verb_valid), .verb_ready_i(verb_ready),
    .verb_o(verb), .verb_cad_o(verb_cad),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data),
    .rsp_unsol_i(rsp_unsol), .rsp_cad_i(rsp_cad)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
    if (verb_valid && verb_ready && nv < 64) begin
      got[nv] = verb;
      got_cad[nv] = verb_cad;
      nv = nv + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d, input logic u, input logic [3:0] c);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d; rsp_unsol = u; rsp_cad = c;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    settle(4);
  endtask

  task automatic t_reset();
    check("R1 rp", 32'(cmd_rp), 0);
    check("R1 wp", 32'(rsp_wp), 0);
    check("R1 irq", 32'(rsp_irq), 0);
    check("R1 valid", 32'(verb_valid), 0);
    check("R1 ready", 32'(rsp_ready), 0);
  endtask

  task automatic t_default_size();  // R1 R3: 256 ring, 20 -> 21 (16 ring would give 5)
    mem[21] = 32'h0123_4567;
    wr(4'h1, 8'd20); wr(4'h0, 8'd21);
    nv = 0; wr(4'h2, 8'h01); settle(30);
    check("R1 count", 32'(nv), 1);
    check("R1 verb", got[0], 32'h0123_4567);
    check("R3 rp", 32'(cmd_rp), 21);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_fetch16();  // R3 R4
    wr(4'h3, 8'h01); wr(4'h1, 8'h00);
    mem[1] = 32'h0000_0AAA; mem[2] = 32'h1000_0BBB;
    mem[3] = 32'h3000_0CCC; mem[4] = 32'h2000_0DDD;
    wr(4'h0, 8'd4);
    nv = 0; wr(4'h2, 8'h01); settle(40);
    check("R4 count drop", 32'(nv), 3);
    check("R3 order0", got[0], 32'h0000_0AAA);
    check("R3 order1", got[1], 32'h1000_0BBB);
    check("R4 third", got[2], 32'h2000_0DDD);
    check("R4 cad", 32'(got_cad[2]), 2);
    check("R3 rp", 32'(cmd_rp), 4);
    wr(4'h0, 8'd0); settle(80);   // indices 5..15 then 0
    check("R2 wrap16 count", 32'(nv), 15);
    check("R2 wrap16 rp", 32'(cmd_rp), 0);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_wrap2();  // R2 R3
    wr(4'h3, 8'h00); wr(4'h1, 8'd1);
    mem[0] = 32'h2000_0EEE;
    wr(4'h0, 8'd0);
    nv = 0; wr(4'h2, 8'h01); settle(20);
    check("R2 wrap2 count", 32'(nv), 1);
    check("R2 wrap2 verb", got[0], 32'h2000_0EEE);
    check("R3 wrap2 rp", 32'(cmd_rp), 0);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_bad_size();  // R2 R3
    wr(4'h3, 8'h03); wr(4'h1, 8'd0); wr(4'h0, 8'd1);
    mem[1] = 32'h1000_0123;
    nv = 0; wr(4'h2, 8'h01); settle(20);
    check("R2 invalid no fetch", 32'(nv), 0);
    check("R2 invalid rp", 32'(cmd_rp), 0);
    wr(4'h3, 8'h01); settle(20);   // no new run edge
    check("R3 needs run edge", 32'(nv), 0);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_stop();  // R5
    int t = 0;
    wr(4'h3, 8'h01); wr(4'h1, 8'd0);
    mem[1] = 32'h1000_0111;
    verb_ready = 1'b0;
    wr(4'h0, 8'd1); wr(4'h2, 8'h01);
    while (!verb_valid && t < 40) begin @(negedge clk); t++; end
    check("R5 offered", 32'(verb_valid), 1);
    wr(4'h2, 8'h00); @(negedge clk);
    check("R5 withdrawn", 32'(verb_valid), 0);
    verb_ready = 1'b1;
    nv = 0; wr(4'h2, 8'h01); settle(10);
    wr(4'h1, 8'd9); settle(2);
    check("R5 rp locked", 32'(cmd_rp), 1);
    check("R5 no refetch", 32'(nv), 0);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_rsp();  // R6 R7
    wr(4'h6, 8'h01); wr(4'h7, 8'd2); wr(4'h5, 8'h03);
    send(32'hCAFE_0001, 1'b0, 4'd1);
    check("R6 data0", mem[RB+2], 32'hCAFE_0001);
    check("R6 ext0", mem[RB+3], 32'h0000_0001);
    check("R6 wp1", 32'(rsp_wp), 1);
    check("R7 below thresh", 32'(rsp_irq), 0);
    send(32'hBEEF_0002, 1'b1, 4'd2);
    check("R6 data1", mem[RB+4], 32'hBEEF_0002);
    check("R6 unsol ext", mem[RB+5], 32'h0000_0012);
    check("R7 flag set", 32'(rsp_irq), 1);
    wr(4'h8, 8'h01); @(negedge clk);
    check("R7 flag clear", 32'(rsp_irq), 0);
    wr(4'h5, 8'h01);
    send(32'h1, 1'b0, 4'd0); send(32'h2, 1'b0, 4'd0);
    check("R7 disabled no flag", 32'(rsp_irq), 0);
    check("R6 wp4", 32'(rsp_wp), 4);
  endtask

  task automatic t_rsp_off();  // R8 R2 R6
    wr(4'h5, 8'h00); @(negedge clk);
    check("R8 not ready", 32'(rsp_ready), 0);
    wr(4'h4, 8'd1); wr(4'h6, 8'h00); wr(4'h5, 8'h03);
    send(32'hAAAA_5555, 1'b0, 4'd2);
    check("R6 wrap2 data", mem[RB], 32'hAAAA_5555);
    check("R6 wrap2 ext", mem[RB+1], 32'h0000_0002);
    check("R2 rsp wp wrap", 32'(rsp_wp), 0);
    check("R8 counter 1", 32'(rsp_irq), 0);
    send(32'h5555_AAAA, 1'b0, 4'd1);
    check("R8 counter reset", 32'(rsp_irq), 1);
    wr(4'h6, 8'h03); @(negedge clk);
    check("R2 invalid rsp size", 32'(rsp_ready), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_default_size();
    t_fetch16();
    t_wrap2();
    t_bad_size();
    t_stop();
    t_rsp();
    t_rsp_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule